// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Status Response

This block is the byte queue that sits behind the data register of a parallel-bus storage controller when the processor moves bytes itself rather than through DMA. Each processor write to the data register either lands in the queue or, while the controller is collecting a command, is appended to a separate command buffer. Each processor read takes the oldest queued byte and raises the interrupt line, so software can pace itself byte by byte.

Two controller commands reuse the queue to return a completion. The first is completion of an initiator command. The second is acceptance of a message. Each loads a two-byte response into the queue: the status (sense) byte first, then a zero message byte. Each also sets the FIFO-flags value to 2, raises the interrupt and updates the interrupt code. The completion command also updates the bus-phase bits. The acceptance command also updates the sequence step. A flush strobe empties the queue at once. A write that arrives when the queue holds one byte less than its depth is dropped and flagged as an overrun.

Top module: `pio_byte_fifo`

## Requirements
- R1: Bytes written while `cmdCollect` is low and the count is below 15 are stored. `fifoCount` rises by one on the next cycle, and the bytes are returned in the order they were written.
- R2: `fifoCount` never exceeds 15 (DEPTH-1), even though the storage has 16 entries.
- R3: A write while `cmdCollect` is low and `fifoCount` is 15 is dropped. `fifoCount` stays at 15, and `overrunErr` is high for exactly the one cycle that follows the write.
- R4: A read with `fifoCount` above zero loads the oldest byte into `rdData` on the next cycle, lowers `fifoCount` by one and sets `irq`.
- R5: A read with `fifoCount` at zero leaves `rdData`, `fifoCount` and `irq` unchanged.
- R6: While `cmdCollect` is high, writes go into the command buffer at index `cmdLen`. `cmdLen` increments and saturates at 16, `fifoCount` is untouched, and the stored bytes are readable through `cmdIdx`/`cmdData`. `cmdClear` sets `cmdLen` to 0.
- R7: Once the queue has drained to zero by reads, or after a flush, the next byte written is the next byte read back, whatever the earlier pointer positions were.
- R8: `flush` takes priority over every other input. On the next cycle `fifoCount` is 0 and `flagsVal` is 0.
- R9: `iccsCmd` or `msgAccCmd` sets `fifoCount` to 2 on the next cycle. The next two reads return `senseByte` and then 0x00. `flagsVal` becomes 2 and `irq` is set. Reads and writes in that same cycle are ignored.
- R10: `iccsCmd` sets `intrCode` to 0x08 (function complete) and `phaseBits` to 3'b111 (message in). `msgAccCmd` sets `intrCode` to 0x20 (disconnect) and `seqStep` to 0. If both are high, `iccsCmd` wins. After reset `intrCode` is 0, `phaseBits` is 0 and `seqStep` is 4.
- R11: `irqAck` clears `irq` on the next cycle, unless a pop or a status load in the same cycle sets it again.
- R12: A read and a write in the same cycle with `fifoCount` between 1 and 14 leave `fifoCount` unchanged and keep the byte order, including across the pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor write to the data register |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Processor read of the data register |
| rdData | output | 8 | Data register read value (held between pops) |
| cmdCollect | input | 1 | Steer writes into the command buffer |
| cmdClear | input | 1 | Reset the command buffer length |
| cmdIdx | input | 4 | Command buffer read index |
| cmdData | output | 8 | Command buffer byte at `cmdIdx` |
| cmdLen | output | 5 | Bytes collected in the command buffer |
| flush | input | 1 | Empty the queue |
| iccsCmd | input | 1 | Initiator command complete: load status response |
| msgAccCmd | input | 1 | Message accepted: load status response |
| senseByte | input | 8 | Status byte for the response |
| irqAck | input | 1 | Clear the interrupt |
| irq | output | 1 | Interrupt request |
| overrunErr | output | 1 | One-cycle pulse after a dropped write |
| fifoCount | output | 5 | Bytes in the queue |
| flagsVal | output | 8 | FIFO-flags value |
| intrCode | output | 8 | Interrupt code |
| seqStep | output | 3 | Sequence step |
| phaseBits | output | 3 | Bus-phase bits |

## Verification
The assertions assume that each strobe is a clean level held for whole cycles, that `rst_n` is low for at least one edge before any check, and that `cmdIdx` addresses only bytes already collected before `cmdData` is used. The bench drives every input one step after a rising edge, returns strobes to zero after a single cycle, and reads `cmdData` only below `cmdLen`. It sweeps the fill from empty up to the overrun point and then drains back. It streams combined reads and writes through more than two pointer wraps, and it exercises both status commands. Each of these carries a predicted count and byte order worked out from the requirements.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;

  // Strobes issued by the control unit to the datapath, one per cycle
  typedef struct packed {
    logic push;        // store wrData into the queue
    logic pop;         // move oldest byte to the read register
    logic cmdPush;     // append wrData to the command buffer
    logic cmdClear;    // zero the command length
    logic clearAll;    // flush: empty queue, rewind pointers
    logic loadStatus;  // load sense byte + zero message byte
  } fifoStrobes_t;

  localparam logic [7:0] INTR_FUNC_DONE  = 8'h08;
  localparam logic [7:0] INTR_DISCONNECT = 8'h20;
  localparam logic [2:0] PHASE_MSG_IN    = 3'b111;
  localparam logic [2:0] SEQ_RESET_STEP  = 3'd4;
  localparam logic [7:0] FLAGS_STATUS    = 8'd2;

endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             cmdCollect,
  input  logic             cmdClear,
  input  logic             flush,
  input  logic             iccsCmd,
  input  logic             msgAccCmd,
  input  logic             irqAck,
  input  logic [CNT_W-1:0] fifoCount,
  output fifoStrobes_t     strobes,
  output logic             irq,
  output logic             overrunErr,
  output logic [7:0]       flagsVal,
  output logic [7:0]       intrCode,
  output logic [2:0]       seqStep,
  output logic [2:0]       phaseBits
);

  localparam logic [CNT_W-1:0] OVR_LIMIT = CNT_W'(DEPTH - 1);

  logic statusAny;
  logic dataWrite;
  logic overrunNow;

  // Priority: flush, then status load, then data/command traffic
  always_comb begin
    statusAny  = (iccsCmd | msgAccCmd) & ~flush;
    dataWrite  = wrEn & ~cmdCollect & ~flush & ~statusAny;
    overrunNow = dataWrite & (fifoCount == OVR_LIMIT);

    strobes            = '0;
    strobes.clearAll   = flush;
    strobes.loadStatus = statusAny;
    strobes.push       = dataWrite & ~overrunNow;
    strobes.pop        = rdEn & ~flush & ~statusAny & (fifoCount != '0);
    strobes.cmdPush    = wrEn & cmdCollect & ~flush & ~statusAny;
    strobes.cmdClear   = cmdClear;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      overrunErr <= 1'b0;
      flagsVal   <= '0;
      intrCode   <= '0;
      seqStep    <= SEQ_RESET_STEP;
      phaseBits  <= '0;
    end else begin
      overrunErr <= overrunNow;
      if (strobes.pop || statusAny) irq <= 1'b1;
      else if (irqAck)               irq <= 1'b0;

      if (flush) flagsVal <= '0;
      else if (statusAny) flagsVal <= FLAGS_STATUS;

      if (statusAny) begin
        if (iccsCmd) begin
          intrCode  <= INTR_FUNC_DONE;
          phaseBits <= PHASE_MSG_IN;
        end else begin
          intrCode <= INTR_DISCONNECT;
          seqStep  <= '0;
        end
      end
    end
  end

  // R3: dropped write keeps the count and flags the overrun next cycle
  a_r3_overrun_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !cmdCollect && !flush && !iccsCmd && !msgAccCmd && !rdEn &&
     fifoCount == OVR_LIMIT) |=> (fifoCount == OVR_LIMIT && overrunErr));

  // R4: a pop with data present raises the interrupt
  a_r4_irq_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !flush && !iccsCmd && !msgAccCmd && fifoCount != '0) |=> irq);

  // R8: flush empties the queue and clears the flags
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifoCount == '0 && flagsVal == '0));

  // R11: acknowledge without a set event drops the line
  a_r11_irq_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !rdEn && !iccsCmd && !msgAccCmd) |=> !irq);

  // R6: command collection leaves the count alone
  a_r6_cmd_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && cmdCollect && !rdEn && !flush && !iccsCmd && !msgAccCmd)
      |=> $stable(fifoCount));

endmodule

// File: rtl/pio_fifo_datapath.sv
module pio_fifo_datapath
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] senseByte,
  input  logic [PTR_W-1:0] cmdIdx,
  output logic [CNT_W-1:0] fifoCount,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] cmdLen,
  output logic [WIDTH-1:0] cmdData
);

  logic [WIDTH-1:0] fifoMem [DEPTH];
  logic [WIDTH-1:0] cmdMem  [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] nextCount;
  logic             cmdRoom;

  always_comb begin
    nextCount = fifoCount + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
    cmdRoom   = (cmdLen < CNT_W'(DEPTH));
  end

  // Storage arrays carry no reset
  always_ff @(posedge clk) begin
    if (strobes.loadStatus) begin
      fifoMem[0] <= senseByte;
      fifoMem[1] <= '0;
    end else if (strobes.push) begin
      fifoMem[wrPtr] <= wrData;
    end
    if (strobes.cmdPush && cmdRoom) cmdMem[cmdLen[PTR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifoCount <= '0;
      rdPtr     <= '0;
      wrPtr     <= '0;
      rdData    <= '0;
    end else if (strobes.clearAll) begin
      fifoCount <= '0;
      rdPtr     <= '0;
      wrPtr     <= '0;
    end else if (strobes.loadStatus) begin
      fifoCount <= CNT_W'(2);
      rdPtr     <= '0;
      wrPtr     <= PTR_W'(2);
    end else begin
      if (strobes.pop) rdData <= fifoMem[rdPtr];
      fifoCount <= nextCount;
      if (nextCount == '0) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        if (strobes.push) wrPtr <= wrPtr + PTR_W'(1);
        if (strobes.pop)  rdPtr <= rdPtr + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmdLen <= '0;
    else if (strobes.cmdClear) cmdLen <= '0;
    else if (strobes.cmdPush && cmdRoom) cmdLen <= cmdLen + CNT_W'(1);
  end

  assign cmdData = cmdMem[cmdIdx];

  // R2: count stays one short of the storage depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= CNT_W'(DEPTH - 1));

  // R7: an empty queue always has both pointers rewound
  a_r7_empty_rewound: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCount == '0) |-> (rdPtr == '0 && wrPtr == '0));

  // R9: status load leaves exactly two bytes queued
  a_r9_status_two: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadStatus && !strobes.clearAll) |=> fifoCount == CNT_W'(2));

  // R12: simultaneous push and pop keep the count
  a_r12_stream_count: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.push && strobes.pop && !strobes.clearAll && !strobes.loadStatus)
      |=> $stable(fifoCount));

  // R6: command length never passes the buffer size
  a_r6_cmd_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmdLen <= CNT_W'(DEPTH));

endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic             cmdCollect,
  input  logic             cmdClear,
  input  logic [PTR_W-1:0] cmdIdx,
  output logic [WIDTH-1:0] cmdData,
  output logic [CNT_W-1:0] cmdLen,
  input  logic             flush,
  input  logic             iccsCmd,
  input  logic             msgAccCmd,
  input  logic [WIDTH-1:0] senseByte,
  input  logic             irqAck,
  output logic             irq,
  output logic             overrunErr,
  output logic [CNT_W-1:0] fifoCount,
  output logic [7:0]       flagsVal,
  output logic [7:0]       intrCode,
  output logic [2:0]       seqStep,
  output logic [2:0]       phaseBits
);

  fifoStrobes_t strobes;

  pio_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn),
    .cmdCollect(cmdCollect), .cmdClear(cmdClear), .flush(flush),
    .iccsCmd(iccsCmd), .msgAccCmd(msgAccCmd), .irqAck(irqAck),
    .fifoCount(fifoCount), .strobes(strobes), .irq(irq),
    .overrunErr(overrunErr), .flagsVal(flagsVal), .intrCode(intrCode),
    .seqStep(seqStep), .phaseBits(phaseBits)
  );

  pio_fifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .senseByte(senseByte), .cmdIdx(cmdIdx), .fifoCount(fifoCount),
    .rdData(rdData), .cmdLen(cmdLen), .cmdData(cmdData)
  );

endmodule

// File: tb/pio_byte_fifo_test.sv
module pio_byte_fifo_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 0, rdEn = 0, cmdCollect = 0, cmdClear = 0, flush = 0;
  logic iccsCmd = 0, msgAccCmd = 0, irqAck = 0;
  logic [7:0] wrData = '0, senseByte = '0;
  logic [3:0] cmdIdx = '0;
  logic [7:0] rdData, cmdData, flagsVal, intrCode;
  logic [4:0] cmdLen, fifoCount;
  logic [2:0] seqStep, phaseBits;
  logic irq, overrunErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  byte unsigned q[$];
  byte unsigned expRd = 0;

  always #2.5 clk = ~clk;

  pio_byte_fifo uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .cmdCollect(cmdCollect), .cmdClear(cmdClear),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .cmdLen(cmdLen), .flush(flush),
    .iccsCmd(iccsCmd), .msgAccCmd(msgAccCmd), .senseByte(senseByte),
    .irqAck(irqAck), .irq(irq), .overrunErr(overrunErr),
    .fifoCount(fifoCount), .flagsVal(flagsVal), .intrCode(intrCode),
    .seqStep(seqStep), .phaseBits(phaseBits)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wrEn = 0; rdEn = 0; flush = 0; iccsCmd = 0; msgAccCmd = 0;
    irqAck = 0; cmdClear = 0;
  endtask

  // One data cycle; the model follows R1, R3, R4, R5
  task automatic step(bit w, byte unsigned d, bit r);
    int sz = q.size();
    wrEn = w; wrData = d; rdEn = r;
    if (r && sz > 0) expRd = q.pop_front();
    if (w && sz < 15) q.push_back(d);
    tick();
  endtask

  function automatic byte unsigned pat(int k);
    return byte'((k * 37 + 11) & 8'hff);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // Reset state (R10 reset values)
    check("R1 reset count", fifoCount, 0);
    check("R11 reset irq", irq, 0);
    check("R10 reset intr", intrCode, 0);
    check("R10 reset seq", seqStep, 4);
    check("R10 reset phase", phaseBits, 0);
    check("R8 reset flags", flagsVal, 0);

    // Fill sweep up to the overrun point (R1, R2, R3)
    for (int k = 0; k < 15; k++) begin
      step(1, pat(k), 0);
      check("R1 fill count", fifoCount, k + 1);
      check("R3 no overrun", overrunErr, 0);
    end
    step(1, 8'hEE, 0);
    check("R3 overrun pulse", overrunErr, 1);
    check("R2 count capped", fifoCount, 15);
    tick();
    check("R3 pulse one cycle", overrunErr, 0);

    // Drain sweep (R4) with acknowledge between pops (R11)
    for (int k = 0; k < 15; k++) begin
      irqAck = 1; tick();
      check("R11 ack clears", irq, 0);
      step(0, 0, 1);
      check("R4 data", rdData, expRd);
      check("R4 data order", rdData, pat(k));
      check("R4 count", fifoCount, 14 - k);
      check("R4 irq", irq, 1);
    end

    // Empty read (R5)
    irqAck = 1; tick();
    step(0, 0, 1);
    check("R5 data held", rdData, pat(14));
    check("R5 count", fifoCount, 0);
    check("R5 irq", irq, 0);

    // Streaming across pointer wrap at several fill levels (R12, R7)
    for (int lvl = 1; lvl <= 14; lvl += 13) begin
      for (int k = 0; k < lvl; k++) step(1, pat(100 + k), 0);
      for (int k = 0; k < 40; k++) begin
        step(1, pat(200 + k), 1);
        check("R12 stream data", rdData, expRd);
        check("R12 stream count", fifoCount, lvl);
      end
      while (q.size() > 0) begin
        step(0, 0, 1);
        check("R12 drain data", rdData, expRd);
      end
      check("R7 drained", fifoCount, 0);
      step(1, 8'h5A, 0);
      step(0, 0, 1);
      check("R7 rewound data", rdData, 8'h5A);
    end

    // Command collection (R6), overfilling past the buffer size
    cmdCollect = 1;
    for (int k = 0; k < 18; k++) begin
      wrEn = 1; wrData = pat(300 + k); tick();
      check("R6 count untouched", fifoCount, 0);
      check("R6 len", cmdLen, (k + 1 > 16) ? 16 : k + 1);
    end
    cmdCollect = 0;
    for (int k = 0; k < 16; k++) begin
      cmdIdx = 4'(k); #1;
      check("R6 cmd byte", cmdData, pat(300 + k));
    end
    cmdClear = 1; tick();
    check("R6 clear", cmdLen, 0);

    // Flush (R8, R7)
    for (int k = 0; k < 3; k++) step(1, pat(400 + k), 0);
    flush = 1; wrEn = 1; wrData = 8'h77; rdEn = 1; tick();
    q.delete();
    check("R8 flush count", fifoCount, 0);
    step(1, 8'hC3, 0);
    step(0, 0, 1);
    check("R7 after flush", rdData, 8'hC3);

    // Initiator completion with a competing write (R9, R10)
    irqAck = 1; tick();
    senseByte = 8'h02; iccsCmd = 1; wrEn = 1; wrData = 8'h99; tick();
    check("R9 status count", fifoCount, 2);
    check("R9 flags", flagsVal, 2);
    check("R9 irq", irq, 1);
    check("R10 iccs intr", intrCode, 8'h08);
    check("R10 iccs phase", phaseBits, 3'b111);
    check("R10 iccs seq", seqStep, 4);
    flush = 1; tick();
    check("R8 flags cleared", flagsVal, 0);
    senseByte = 8'h02; iccsCmd = 1; tick();
    rdEn = 1; tick();
    check("R9 first byte", rdData, 8'h02);
    rdEn = 1; tick();
    check("R9 second byte", rdData, 8'h00);
    check("R9 emptied", fifoCount, 0);

    // Message accepted, then both together (R10)
    senseByte = 8'h00; msgAccCmd = 1; tick();
    check("R10 msg intr", intrCode, 8'h20);
    check("R10 msg seq", seqStep, 0);
    check("R10 msg phase kept", phaseBits, 3'b111);
    check("R9 msg count", fifoCount, 2);
    senseByte = 8'h11; msgAccCmd = 1; iccsCmd = 1; tick();
    check("R10 iccs priority", intrCode, 8'h08);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule